// File: doc/BRIEF.md
# Interrupt IN Endpoint Packet Buffer

This block holds one short outgoing packet for a USB interrupt IN endpoint. Software loads bytes one at a time into an eight-byte store and then pulses a commit trigger to mark the packet as ready. Until that commit, every IN token from the host is answered with NAK. Once the packet is committed, an IN token starts a byte stream toward the serial engine. A packet with no bytes is sent as a zero-length packet.

After the last byte goes out, the block waits for the host handshake. If the host sends an ACK, the buffer empties itself and raises a transmit-complete flag. That flag stays set until software writes one to clear it. If the host sends another IN token before any ACK, the same packet is sent again from its first byte.

While a committed packet is pending, software writes are thrown away. A flush input returns the store to empty at any time and abandons a pending or half-sent packet. Token decoding and bus timing belong to the neighbouring serial engine.

Top module: `usb_intin_ep`

## Requirements
- R1: After reset, the fill count is 0, ready is low, the transmit-complete flag is low, and no data, NAK or zero-length strobe is driven.
- R2: Accepted bytes are stored in write order, and each one increments the fill count. Writes made when the count has reached the depth of 8 are dropped.
- R3: A commit pulse raises ready. An IN token that arrives while ready is low gives a one-cycle NAK pulse in the following cycle and sends no data.
- R4: An IN token that arrives while ready is high and the count is nonzero starts a stream in the next cycle. The stream puts out one byte per cycle, in write order, for exactly "count" cycles, and tx_last is high on the final byte only.
- R5: An IN token on a committed packet of zero bytes gives a one-cycle zero-length strobe in the next cycle and no data beats.
- R6: An ACK that arrives after the last byte (or after the zero-length strobe) sets the transmit-complete flag in the next cycle. In that same cycle the count drops to 0 and ready falls.
- R7: An ACK that arrives before the packet has been sent has no effect. An IN token that arrives after sending but before any ACK resends the whole packet from its first byte.
- R8: The transmit-complete flag holds until irq_clr is pulsed. If a clear and a setting ACK fall in the same cycle, the flag ends up set.
- R9: While ready is high, writes change neither the fill count nor the stored bytes.
- R10: A flush pulse makes the count 0 and ready low in the next cycle, stops any stream in progress, and leaves the transmit-complete flag unchanged.
- R11: An IN token that arrives while a stream is in progress does not disturb that stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Flush pulse: empties the buffer |
| wr_en_i | input | 1 | Software byte write strobe |
| wr_data_i | input | DATA_W | Byte to store |
| commit_i | input | 1 | Packet commit trigger |
| irq_clr_i | input | 1 | Write-one-to-clear for the transmit-complete flag |
| in_token_i | input | 1 | IN token received for this endpoint |
| ack_i | input | 1 | Host ACK handshake received |
| ready_o | output | 1 | A committed packet is pending |
| fill_cnt_o | output | CNT_W | Number of bytes held |
| tx_valid_o | output | 1 | Data beat valid |
| tx_data_o | output | DATA_W | Data beat |
| tx_last_o | output | 1 | Final data beat of the packet |
| tx_zlp_o | output | 1 | Zero-length packet strobe |
| nak_o | output | 1 | NAK pulse answering an IN token |
| txc_flag_o | output | 1 | Transmit-complete interrupt flag |

## Verification
The hardest state to reach is the wait after transmission with no ACK yet, because only there do a repeated token, a late ACK and a flag clear all interact. The stimulus reaches this state in a few ways. It sends a packet and withholds the ACK, so that a second token must replay the bytes. It also lines up an ACK and a flag clear in the same cycle while an earlier flag is still set. Separately, it fires a token in the middle of a stream and a flush in the middle of a stream, and then checks that the stream survives the token and that the flush leaves the flag unchanged.

// File: rtl/ep_intin_pkg.sv
package ep_intin_pkg;
   typedef enum logic [1:0] {
      ST_FILL  = 2'd0,
      ST_READY = 2'd1,
      ST_SEND  = 2'd2,
      ST_WAIT  = 2'd3
   } ep_state_e;
endpackage

// File: rtl/ep_intin_store.sv
module ep_intin_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 4,
   parameter int PTR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              drop_i,
   input  logic              lock_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_ptr_i,
   output logic [CNT_W-1:0]  len_o,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [CNT_W-1:0]  len_q;
   logic              accept;
   logic [DATA_W-1:0] mem_w [DEPTH];

   assign accept = wr_en_i && !lock_i && !flush_i && (len_q < CNT_W'(DEPTH));

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '0;
         else if (accept && len_q == CNT_W'(g))
            cell_q <= wr_data_i;
      end
      assign mem_w[g] = cell_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_q <= '0;
      else if (flush_i || drop_i)
         len_q <= '0;
      else if (accept)
         len_q <= len_q + CNT_W'(1);
   end

   assign len_o     = len_q;
   assign rd_data_o = mem_w[rd_ptr_i];
endmodule

// File: rtl/ep_intin_ctrl.sv
module ep_intin_ctrl
   import ep_intin_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             commit_i,
   input  logic             token_i,
   input  logic             ack_i,
   input  logic [CNT_W-1:0] len_i,
   output ep_state_e        state_o,
   output logic [PTR_W-1:0] rd_ptr_o,
   output logic             last_o,
   output logic             done_o,
   output logic             nak_o,
   output logic             zlp_o
);
   ep_state_e        state_q;
   logic [PTR_W-1:0] ptr_q;
   logic             nak_q, zlp_q;
   logic             last;

   assign last   = (CNT_W'(ptr_q) == len_i - CNT_W'(1));
   assign done_o = (state_q == ST_WAIT) && ack_i && !flush_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FILL;
         ptr_q   <= '0;
         nak_q   <= 1'b0;
         zlp_q   <= 1'b0;
      end else begin
         nak_q <= 1'b0;
         zlp_q <= 1'b0;
         if (flush_i) begin
            state_q <= ST_FILL;
            ptr_q   <= '0;
         end else begin
            unique case (state_q)
               ST_FILL: begin
                  if (token_i)  nak_q   <= 1'b1;
                  if (commit_i) state_q <= ST_READY;
               end
               ST_READY, ST_WAIT: begin
                  if (state_q == ST_WAIT && ack_i) begin
                     state_q <= ST_FILL;
                     ptr_q   <= '0;
                  end else if (token_i) begin
                     ptr_q <= '0;
                     if (len_i == '0) begin
                        zlp_q   <= 1'b1;
                        state_q <= ST_WAIT;
                     end else begin
                        state_q <= ST_SEND;
                     end
                  end
               end
               ST_SEND: begin
                  if (last) state_q <= ST_WAIT;
                  else      ptr_q   <= ptr_q + PTR_W'(1);
               end
               default: state_q <= ST_FILL;
            endcase
         end
      end
   end

   assign state_o  = state_q;
   assign rd_ptr_o = ptr_q;
   assign last_o   = last;
   assign nak_o    = nak_q;
   assign zlp_o    = zlp_q;
endmodule

// File: rtl/ep_intin_flag.sv
module ep_intin_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/usb_intin_ep.sv
module usb_intin_ep
   import ep_intin_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              commit_i,
   input  logic              irq_clr_i,
   input  logic              in_token_i,
   input  logic              ack_i,
   output logic              ready_o,
   output logic [CNT_W-1:0]  fill_cnt_o,
   output logic              tx_valid_o,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_last_o,
   output logic              tx_zlp_o,
   output logic              nak_o,
   output logic              txc_flag_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("usb_intin_ep: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("usb_intin_ep: DATA_W must be positive");
   end

   ep_state_e         state;
   logic [PTR_W-1:0]  rd_ptr;
   logic [DATA_W-1:0] rd_data;
   logic              last, done, locked;

   assign locked = (state != ST_FILL);

   ep_intin_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush_i),
      .drop_i    (done),
      .lock_i    (locked),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .rd_ptr_i  (rd_ptr),
      .len_o     (fill_cnt_o),
      .rd_data_o (rd_data)
   );

   ep_intin_ctrl #(
      .CNT_W(CNT_W), .PTR_W(PTR_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_i  (flush_i),
      .commit_i (commit_i),
      .token_i  (in_token_i),
      .ack_i    (ack_i),
      .len_i    (fill_cnt_o),
      .state_o  (state),
      .rd_ptr_o (rd_ptr),
      .last_o   (last),
      .done_o   (done),
      .nak_o    (nak_o),
      .zlp_o    (tx_zlp_o)
   );

   ep_intin_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (done),
      .clr_i  (irq_clr_i),
      .flag_o (txc_flag_o)
   );

   assign ready_o    = locked;
   assign tx_valid_o = (state == ST_SEND);
   assign tx_data_o  = tx_valid_o ? rd_data : '0;
   assign tx_last_o  = tx_valid_o && last;
endmodule

// File: rtl/ep_intin_chk.sv
module ep_intin_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush_i,
   input logic             wr_en_i,
   input logic             ack_i,
   input logic             in_token_i,
   input logic             irq_clr_i,
   input logic             ready_o,
   input logic [CNT_W-1:0] fill_cnt_o,
   input logic             tx_valid_o,
   input logic             tx_last_o,
   input logic             tx_zlp_o,
   input logic             nak_o,
   input logic             txc_flag_o
);
   // R2
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt_o <= CNT_W'(DEPTH));

   // R3
   nak_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_token_i && !ready_o && !flush_i) |=> nak_o);

   // R4
   beat_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_valid_o, nak_o, tx_zlp_o}));

   // R4
   last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last_o |-> (tx_valid_o && ready_o));

   // R6
   ack_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txc_flag_o) |-> (fill_cnt_o == '0 && !ready_o));

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txc_flag_o && !irq_clr_i) |=> txc_flag_o);

   // R9
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && wr_en_i && !flush_i && !ack_i) |=> $stable(fill_cnt_o));

   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (fill_cnt_o == '0 && !ready_o && !tx_valid_o));

   // R10
   flush_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i && !irq_clr_i) |=> $stable(txc_flag_o));
endmodule

bind usb_intin_ep ep_intin_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush_i    (flush_i),
   .wr_en_i    (wr_en_i),
   .ack_i      (ack_i),
   .in_token_i (in_token_i),
   .irq_clr_i  (irq_clr_i),
   .ready_o    (ready_o),
   .fill_cnt_o (fill_cnt_o),
   .tx_valid_o (tx_valid_o),
   .tx_last_o  (tx_last_o),
   .tx_zlp_o   (tx_zlp_o),
   .nak_o      (nak_o),
   .txc_flag_o (txc_flag_o)
);

// File: tb/usb_intin_ep_test.sv
`timescale 1ns/1ps
module usb_intin_ep_test;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 8;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   // vector: {writes[15:12], seed[11:4], expected count[3:0]}
   localparam int NVEC = 6;
   localparam logic [15:0] VEC [NVEC] = '{
      {4'd1,  8'h10, 4'd1},
      {4'd8,  8'h20, 4'd8},
      {4'd10, 8'h30, 4'd8},
      {4'd3,  8'hA5, 4'd3},
      {4'd5,  8'hFD, 4'd5},
      {4'd0,  8'h00, 4'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_i = 0, wr_en_i = 0, commit_i = 0, irq_clr_i = 0, in_token_i = 0, ack_i = 0;
   logic [DATA_W-1:0] wr_data_i = '0;
   logic ready_o, tx_valid_o, tx_last_o, tx_zlp_o, nak_o, txc_flag_o;
   logic [CNT_W-1:0] fill_cnt_o;
   logic [DATA_W-1:0] tx_data_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   usb_intin_ep #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .wr_en_i(wr_en_i),
      .wr_data_i(wr_data_i), .commit_i(commit_i), .irq_clr_i(irq_clr_i),
      .in_token_i(in_token_i), .ack_i(ack_i), .ready_o(ready_o),
      .fill_cnt_o(fill_cnt_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
      .tx_last_o(tx_last_o), .tx_zlp_o(tx_zlp_o), .nak_o(nak_o),
      .txc_flag_o(txc_flag_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_bytes(input int n, input logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); wr_en_i = 1; wr_data_i = seed + 8'(i);
      end
      @(negedge clk); wr_en_i = 0;
   endtask

   task automatic pulse_commit();
      @(negedge clk); commit_i = 1;
      @(negedge clk); commit_i = 0;
   endtask

   task automatic pulse_token();
      @(negedge clk); in_token_i = 1;
      @(negedge clk); in_token_i = 0;
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack_i = 1;
      @(negedge clk); ack_i = 0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); irq_clr_i = 1;
      @(negedge clk); irq_clr_i = 0;
   endtask

   // called right after pulse_token: first beat is visible now
   task automatic expect_stream(input int n, input logic [7:0] seed, input string req);
      for (int i = 0; i < n; i++) begin
         chk(tx_valid_o && tx_data_o == seed + 8'(i) && tx_last_o == (i == n - 1),
             req, {tx_valid_o, tx_last_o, tx_data_o}, {2'b10 | 2'(i == n - 1), seed + 8'(i)});
         @(negedge clk);
      end
      chk(!tx_valid_o, req, tx_valid_o, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(fill_cnt_o == 0 && !ready_o && !txc_flag_o, "R1", {fill_cnt_o, ready_o, txc_flag_o}, 0);
      chk(!tx_valid_o && !nak_o && !tx_zlp_o, "R1", {tx_valid_o, nak_o, tx_zlp_o}, 0);
      rst_n = 1;
      @(negedge clk);

      // vector table walk: R2 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         int nw, ne;
         logic [7:0] sd;
         nw = int'(VEC[v][15:12]);
         sd = VEC[v][11:4];
         ne = int'(VEC[v][3:0]);
         write_bytes(nw, sd);
         chk(fill_cnt_o == CNT_W'(ne), "R2", fill_cnt_o, ne);
         pulse_commit();
         chk(ready_o, "R3", ready_o, 1);
         pulse_token();
         if (ne == 0) begin
            chk(tx_zlp_o && !tx_valid_o, "R5", {tx_zlp_o, tx_valid_o}, 2'b10);
            @(negedge clk);
            chk(!tx_zlp_o, "R5", tx_zlp_o, 0);
         end else begin
            expect_stream(ne, sd, "R4");
         end
         pulse_ack();
         chk(txc_flag_o && fill_cnt_o == 0 && !ready_o, "R6",
             {txc_flag_o, fill_cnt_o, ready_o}, {1'b1, CNT_W'(0), 1'b0});
         pulse_clr();
         chk(!txc_flag_o, "R8", txc_flag_o, 0);
      end

      // R3: token before commit is NAKed
      write_bytes(2, 8'h60);
      pulse_token();
      chk(nak_o && !tx_valid_o, "R3", {nak_o, tx_valid_o}, 2'b10);
      @(negedge clk);
      chk(!nak_o, "R3", nak_o, 0);

      // R7: ack before sending ignored
      pulse_commit();
      pulse_ack();
      chk(!txc_flag_o && ready_o && fill_cnt_o == 2, "R7",
          {txc_flag_o, ready_o, fill_cnt_o}, {2'b01, CNT_W'(2)});
      // R7: no ack, resend from first byte
      pulse_token();
      expect_stream(2, 8'h60, "R7");
      repeat (2) @(negedge clk);
      chk(!txc_flag_o && ready_o, "R7", {txc_flag_o, ready_o}, 2'b01);
      pulse_token();
      expect_stream(2, 8'h60, "R7");
      pulse_ack();
      chk(txc_flag_o, "R6", txc_flag_o, 1);

      // R8: flag holds while uncleared
      repeat (3) @(negedge clk);
      chk(txc_flag_o, "R8", txc_flag_o, 1);

      // R9: writes while committed are discarded
      write_bytes(3, 8'h40);
      pulse_commit();
      write_bytes(4, 8'h90);
      chk(fill_cnt_o == 3, "R9", fill_cnt_o, 3);
      // R11: token in the middle of the stream
      pulse_token();
      for (int i = 0; i < 3; i++) begin
         chk(tx_valid_o && tx_data_o == 8'h40 + 8'(i), "R11", tx_data_o, 8'h40 + i);
         in_token_i = (i == 0);
         @(negedge clk);
      end
      in_token_i = 0;
      chk(!tx_valid_o && !nak_o, "R11", {tx_valid_o, nak_o}, 0);

      // R8: set wins over clear in the same cycle
      @(negedge clk); ack_i = 1; irq_clr_i = 1;
      @(negedge clk); ack_i = 0; irq_clr_i = 0;
      chk(txc_flag_o && !ready_o, "R8", {txc_flag_o, ready_o}, 2'b10);

      // R10: flush mid-stream, flag untouched
      write_bytes(5, 8'h70);
      pulse_commit();
      pulse_token();
      @(negedge clk);
      @(negedge clk); flush_i = 1;
      @(negedge clk); flush_i = 0;
      chk(fill_cnt_o == 0 && !ready_o && !tx_valid_o, "R10",
          {fill_cnt_o, ready_o, tx_valid_o}, 0);
      chk(txc_flag_o, "R10", txc_flag_o, 1);
      pulse_token();
      chk(nak_o, "R10", nak_o, 1);
      pulse_clr();
      chk(!txc_flag_o, "R8", txc_flag_o, 0);

      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule